// File: doc/BRIEF.md
# Pin-to-Vector Interrupt Delivery Engine

This block sits between a bank of interrupt pins and the processor-side interrupt controller. Each pin has a routing entry held by a separate register block. The entry gives a vector, a destination, a destination mode, a delivery type, a polarity, a trigger type and a mask. The engine turns pin levels and service requests into single interrupt messages. It hands each message out on a valid/ready port. When an assertion cannot produce a message, the engine raises a per-pin pulse that marks the assertion as merged, so the loss can be seen.

Level-triggered pins use a remote in-service flag. A level pin fires once, then stays quiet until an end-of-interrupt message for its vector clears the flag, or until the register block clears it. If the pin is still active at that point, it fires again. End-of-interrupt messages are first checked against a 256-entry map of the vectors in use. The map is rebuilt only when the register block signals that an entry changed. Pin 0 is always sent in physical mode to the boot processor.

Top module: `irq_route_engine`

## Requirements
- R1: A pin's effective level is its raw input XOR its polarity bit (1 = active low). Only the effective level drives triggering, and a pending bit follows it each cycle.
- R2: An edge-triggered pin (level bit 0) requests once per 0-to-1 change of its effective level. Two cases report a merged pulse on `coal[i]` one cycle after the event: a service request while the pin is already pending, and a new rise while an earlier request is still unsent.
- R3: A level-triggered pin (level bit 1) requests while its effective level is high and its remote flag is clear. A rise or a service request while the remote flag is set produces a merged pulse and no message.
- R4: A masked pin (mask bit 1) never produces a message and never reports a merged pulse.
- R5: The valid-and-ready handshake of a level message sets that pin's remote flag. A pulse on `rirr_clr[i]` clears the flag, and the pin fires again if it is still pending.
- R6: A level end-of-interrupt (`eoi_level`=1) clears the remote flag of every level entry whose vector equals `eoi_vec`. Such an entry is then resent if it is unmasked and pending. An end-of-interrupt with `eoi_level`=0 leaves the remote flags unchanged.
- R7: A message from pin 0 always carries destination `boot_id` and destination mode 0 (physical), whatever its entry says.
- R8: The vector-in-use map is empty after reset and is rebuilt from all entry vectors when `cfg_changed` pulses. An end-of-interrupt whose vector is absent from the map is ignored.
- R9: When several pins request, the lowest pin index is sent first. The others wait and are sent in later messages.
- R10: `msg_valid` rises two cycles after the effective rise. The message stays unchanged while `msg_ready` is low. After a handshake, `msg_valid` is low for one cycle before the next message.
- R11: After reset, `msg_valid` and `coal` are 0, and every pending bit and remote flag is clear.
- R12: A message carries the pin index, the vector, the destination, the destination mode, the delivery type and the trigger type taken from the pin's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | NPINS | Raw pin levels |
| cfg_pol | input | NPINS | Polarity per pin, 1 = active low |
| cfg_level | input | NPINS | Trigger type per pin, 1 = level |
| cfg_mask | input | NPINS | Mask per pin, 1 = masked |
| cfg_dmode | input | NPINS | Destination mode per pin, 1 = logical |
| cfg_vec | input | NPINS*VEC_W | Vector per pin, pin i at bits i*VEC_W |
| cfg_dest | input | NPINS*DEST_W | Destination per pin |
| cfg_dlv | input | NPINS*DLV_W | Delivery type per pin |
| cfg_changed | input | 1 | Pulse: an entry changed, rebuild the vector map |
| rirr_clr | input | NPINS | Pulse: clear the remote flag of the pin |
| svc_req | input | NPINS | Pulse: treat as a fresh assertion of the pin |
| boot_id | input | DEST_W | Destination used for pin 0 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | VEC_W | End-of-interrupt vector |
| eoi_level | input | 1 | End-of-interrupt trigger type, 1 = level |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted |
| msg_pin | output | PIN_W | Source pin index |
| msg_vec | output | VEC_W | Vector |
| msg_dest | output | DEST_W | Destination |
| msg_dmode | output | 1 | Destination mode |
| msg_dlv | output | DLV_W | Delivery type |
| msg_level | output | 1 | Trigger type |
| coal | output | NPINS | Per-pin merged-assertion pulse |

## Verification
Some properties are checked on every cycle: a held message stays unchanged while ready is low; a remote flag only rises after the handshake of a level message; a merged pulse never comes from a masked pin; pin 0 messages carry the boot destination; at most one pin is granted per cycle; and a map rebuild always contains pin 0's vector. Other behaviour needs whole sequences and is shown only by the bench scenarios. These are: the remote flag blocking a level pin until a matching end-of-interrupt, the refusal of an end-of-interrupt whose vector is stale in the map, lowest-index ordering between two pins that rise together, and the exact cycles when merged pulses and messages appear.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    // per-pin tracking state
    typedef struct packed {
        logic pend;   // effective level seen last cycle
        logic want;   // edge request awaiting a message slot
        logic rirr;   // level message in service at the processor
        logic coal;   // merged-assertion pulse
    } pin_state_t;
endpackage

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic pol,
    input  logic level_mode,
    input  logic masked,
    input  logic svc,
    input  logic grant,
    input  logic delivered,
    input  logic rirr_clr,
    input  logic eoi_clr,
    output logic req,
    output logic coal
);
    pin_state_t s_q, s_d;
    logic eff, rise, assert_ev;

    always_comb begin
        eff       = pin_raw ^ pol;
        rise      = eff & ~s_q.pend;
        assert_ev = eff & (rise | svc);
        s_d       = s_q;
        s_d.pend  = eff;
        s_d.coal  = 1'b0;
        if (rirr_clr | eoi_clr) s_d.rirr = 1'b0;
        if (level_mode) begin
            s_d.want = 1'b0;
            if (delivered) s_d.rirr = 1'b1;
            if (assert_ev & ~masked & s_q.rirr) s_d.coal = 1'b1;
        end else begin
            if (grant) s_d.want = 1'b0;
            if (masked) begin
                s_d.want = 1'b0;
            end else if (assert_ev) begin
                if (~rise | (s_q.want & ~grant)) s_d.coal = 1'b1;
                else                              s_d.want = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req  = masked ? 1'b0 : (level_mode ? (s_q.pend & ~s_q.rirr) : s_q.want);
    assign coal = s_q.coal;

    // R5
    rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.rirr) |-> $past(delivered && level_mode));
    // R4
    coal_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coal |-> !$past(masked));
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
    parameter int NPINS = 8,
    parameter int VEC_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd,
    input  logic [NPINS*VEC_W-1:0] vecs,
    input  logic [VEC_W-1:0]       eoi_vec,
    output logic                   hit
);
    localparam int MAP_N = 1 << VEC_W;
    logic [MAP_N-1:0] map_q, map_d;

    always_comb begin
        map_d = map_q;
        if (upd) begin
            map_d = '0;
            for (int i = 0; i < NPINS; i++) map_d[vecs[i*VEC_W +: VEC_W]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    assign hit = map_q[eoi_vec];

    // R8
    map_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> map_q[$past(vecs[VEC_W-1:0])]);
endmodule

// File: rtl/irq_pick_low.sv
module irq_pick_low #(
    parameter int NPINS = 8,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [NPINS-1:0] req,
    input  logic             en,
    output logic [NPINS-1:0] grant,
    output logic [PIN_W-1:0] idx
);
    logic found;
    always_comb begin
        grant = '0;
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            if (en && req[i] && !found) begin
                grant[i] = 1'b1;
                idx      = PIN_W'(i);
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine #(
    parameter int NPINS  = 8,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    parameter int DLV_W  = 3,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        pin_in,
    input  logic [NPINS-1:0]        cfg_pol,
    input  logic [NPINS-1:0]        cfg_level,
    input  logic [NPINS-1:0]        cfg_mask,
    input  logic [NPINS-1:0]        cfg_dmode,
    input  logic [NPINS*VEC_W-1:0]  cfg_vec,
    input  logic [NPINS*DEST_W-1:0] cfg_dest,
    input  logic [NPINS*DLV_W-1:0]  cfg_dlv,
    input  logic                    cfg_changed,
    input  logic [NPINS-1:0]        rirr_clr,
    input  logic [NPINS-1:0]        svc_req,
    input  logic [DEST_W-1:0]       boot_id,
    input  logic                    eoi_valid,
    input  logic [VEC_W-1:0]        eoi_vec,
    input  logic                    eoi_level,
    output logic                    msg_valid,
    input  logic                    msg_ready,
    output logic [PIN_W-1:0]        msg_pin,
    output logic [VEC_W-1:0]        msg_vec,
    output logic [DEST_W-1:0]       msg_dest,
    output logic                    msg_dmode,
    output logic [DLV_W-1:0]        msg_dlv,
    output logic                    msg_level,
    output logic [NPINS-1:0]        coal
);
    typedef struct packed {
        logic              valid;
        logic [PIN_W-1:0]  pin;
        logic [VEC_W-1:0]  vec;
        logic [DEST_W-1:0] dest;
        logic              dmode;
        logic [DLV_W-1:0]  dlv;
        logic              lvl;
    } msg_t;

    msg_t msg_q, msg_d;
    logic [NPINS-1:0] req, grant, delivered, eoi_clr;
    logic [PIN_W-1:0] pick;
    logic             map_hit, load_en;

    irq_vec_map #(.NPINS(NPINS), .VEC_W(VEC_W)) u_map (
        .clk(clk), .rst_n(rst_n), .upd(cfg_changed), .vecs(cfg_vec),
        .eoi_vec(eoi_vec), .hit(map_hit));

    assign load_en = ~msg_q.valid;

    irq_pick_low #(.NPINS(NPINS)) u_pick (
        .req(req), .en(load_en), .grant(grant), .idx(pick));

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign delivered[g] = msg_q.valid & msg_ready & (msg_q.pin == PIN_W'(g));
        assign eoi_clr[g]   = eoi_valid & map_hit & eoi_level & cfg_level[g]
                            & (cfg_vec[g*VEC_W +: VEC_W] == eoi_vec);
        irq_pin_ctrl u_pin (
            .clk(clk), .rst_n(rst_n), .pin_raw(pin_in[g]), .pol(cfg_pol[g]),
            .level_mode(cfg_level[g]), .masked(cfg_mask[g]), .svc(svc_req[g]),
            .grant(grant[g]), .delivered(delivered[g]), .rirr_clr(rirr_clr[g]),
            .eoi_clr(eoi_clr[g]), .req(req[g]), .coal(coal[g]));
    end

    always_comb begin
        int sel;
        sel   = int'(pick);
        msg_d = msg_q;
        if (msg_q.valid & msg_ready) msg_d.valid = 1'b0;
        if (load_en & (|req)) begin
            msg_d.valid = 1'b1;
            msg_d.pin   = pick;
            msg_d.vec   = cfg_vec[sel*VEC_W +: VEC_W];
            msg_d.dest  = cfg_dest[sel*DEST_W +: DEST_W];
            msg_d.dmode = cfg_dmode[sel];
            msg_d.dlv   = cfg_dlv[sel*DLV_W +: DLV_W];
            msg_d.lvl   = cfg_level[sel];
            if (sel == 0) begin
                msg_d.dest  = boot_id;
                msg_d.dmode = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) msg_q <= '0;
        else        msg_q <= msg_d;
    end

    assign msg_valid = msg_q.valid;
    assign msg_pin   = msg_q.pin;
    assign msg_vec   = msg_q.vec;
    assign msg_dest  = msg_q.dest;
    assign msg_dmode = msg_q.dmode;
    assign msg_dlv   = msg_q.dlv;
    assign msg_level = msg_q.lvl;

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_q)));
    // R7
    boot_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(msg_valid) && msg_pin == '0) |-> (msg_dest == $past(boot_id) && !msg_dmode));
    // R9
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: tb/irq_route_engine_bench.sv
module irq_route_engine_bench;
    localparam int NP = 8;
    logic clk = 0, rst_n = 0;
    logic [NP-1:0] pin_in = '0, cfg_pol = '0, cfg_level = '0, cfg_mask = '1, cfg_dmode = '0;
    logic [NP*8-1:0] cfg_vec = '0, cfg_dest = '0;
    logic [NP*3-1:0] cfg_dlv = '0;
    logic cfg_changed = 0, eoi_valid = 0, eoi_level = 0, msg_ready = 0;
    logic [NP-1:0] rirr_clr = '0, svc_req = '0, coal;
    logic [7:0] boot_id = 8'hB0, eoi_vec = '0, msg_vec, msg_dest;
    logic msg_valid, msg_dmode, msg_level;
    logic [2:0] msg_pin, msg_dlv;
    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    irq_route_engine u_irq_route_engine (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_pol(cfg_pol), .cfg_level(cfg_level),
        .cfg_mask(cfg_mask), .cfg_dmode(cfg_dmode), .cfg_vec(cfg_vec), .cfg_dest(cfg_dest),
        .cfg_dlv(cfg_dlv), .cfg_changed(cfg_changed), .rirr_clr(rirr_clr), .svc_req(svc_req),
        .boot_id(boot_id), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .eoi_level(eoi_level),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_pin(msg_pin), .msg_vec(msg_vec),
        .msg_dest(msg_dest), .msg_dmode(msg_dmode), .msg_dlv(msg_dlv), .msg_level(msg_level),
        .coal(coal));

    typedef struct packed {
        logic [2:0] pin; logic [7:0] vec; logic [7:0] dest;
        logic dmode; logic [2:0] dlv; logic pol;
    } tv_t;
    localparam tv_t TBL [6] = '{
        '{3'd1, 8'h31, 8'h11, 1'b0, 3'd0, 1'b0},
        '{3'd6, 8'h36, 8'h66, 1'b1, 3'd4, 1'b0},
        '{3'd2, 8'h72, 8'h22, 1'b1, 3'd1, 1'b1},
        '{3'd0, 8'h20, 8'h99, 1'b1, 3'd2, 1'b0},
        '{3'd7, 8'hE7, 8'hF7, 1'b0, 3'd7, 1'b1},
        '{3'd0, 8'h21, 8'h05, 1'b1, 3'd5, 1'b1}
    };

    task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setpin(input int i, input logic [7:0] v, input logic [7:0] d, input logic dm,
                          input logic [2:0] dl, input logic p, input logic lv);
        cfg_mask[i] = 1'b1;
        cfg_vec[i*8 +: 8] = v; cfg_dest[i*8 +: 8] = d; cfg_dlv[i*3 +: 3] = dl;
        cfg_dmode[i] = dm; cfg_pol[i] = p; cfg_level[i] = lv; pin_in[i] = p;
        cfg_changed = 1; step(1); cfg_changed = 0; step(1);
        cfg_mask[i] = 1'b0; step(1);
    endtask

    task automatic handshake;
        msg_ready = 1; step(1); msg_ready = 0;
    endtask

    initial begin
        #(8*200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(2);
        // R11 reset state
        chk("R11 valid in reset", msg_valid == 0, msg_valid, 0);
        rst_n = 1; step(2);
        chk("R11 valid after reset", msg_valid == 0, msg_valid, 0);
        chk("R11 coal after reset", coal == 0, coal, 0);

        // table walk: R1 polarity, R12 fields, R7 pin 0, R10 latency
        for (int k = 0; k < 6; k++) begin
            tv_t t = TBL[k];
            logic [7:0] ed; logic edm;
            ed  = (t.pin == 0) ? boot_id : t.dest;
            edm = (t.pin == 0) ? 1'b0 : t.dmode;
            setpin(int'(t.pin), t.vec, t.dest, t.dmode, t.dlv, t.pol, 1'b0);
            pin_in[t.pin] = ~t.pol;
            step(1);
            chk("R10 not yet valid", msg_valid == 0, msg_valid, 0);
            step(1);
            chk("R1 delivered on effective rise", msg_valid == 1, msg_valid, 1);
            chk("R12 pin", msg_pin == t.pin, msg_pin, t.pin);
            chk("R12 vec", msg_vec == t.vec, msg_vec, t.vec);
            chk("R7 R12 dest", msg_dest == ed, msg_dest, ed);
            chk("R7 R12 dmode", msg_dmode == edm, msg_dmode, edm);
            chk("R12 dlv", msg_dlv == t.dlv, msg_dlv, t.dlv);
            chk("R12 trigger", msg_level == 0, msg_level, 0);
            handshake;
            chk("R10 drop after handshake", msg_valid == 0, msg_valid, 0);
            pin_in[t.pin] = t.pol; cfg_mask[t.pin] = 1; step(2);
        end

        // R4 masked pin
        setpin(3, 8'h43, 8'h01, 0, 0, 0, 0);
        cfg_mask[3] = 1; step(1);
        pin_in[3] = 1; step(1); svc_req[3] = 1; step(1); svc_req[3] = 0;
        chk("R4 no coal when masked", coal == 0, coal, 0);
        step(3);
        chk("R4 no message when masked", msg_valid == 0, msg_valid, 0);
        pin_in[3] = 0; step(2);

        // R2 edge merge on service request while pending
        setpin(2, 8'h52, 8'h02, 0, 0, 0, 0);
        pin_in[2] = 1; step(2);
        chk("R2 edge message", msg_valid == 1 && msg_pin == 2, msg_pin, 2);
        svc_req[2] = 1; step(1); svc_req[2] = 0;
        chk("R2 merged pulse", coal == 8'h04, coal, 8'h04);
        step(1);
        chk("R2 merged pulse one cycle", coal == 0, coal, 0);
        handshake; step(3);
        chk("R2 no second message", msg_valid == 0, msg_valid, 0);
        pin_in[2] = 0; cfg_mask[2] = 1; step(2);

        // R9 priority and R10 hold
        setpin(1, 8'h61, 8'h10, 0, 0, 0, 0);
        setpin(5, 8'h65, 8'h50, 0, 0, 0, 0);
        pin_in[1] = 1; pin_in[5] = 1; step(2);
        chk("R9 lowest first", msg_valid == 1 && msg_pin == 1, msg_pin, 1);
        step(3);
        chk("R10 held while not ready", msg_valid == 1 && msg_vec == 8'h61, msg_vec, 8'h61);
        handshake;
        chk("R10 bubble after handshake", msg_valid == 0, msg_valid, 0);
        step(1);
        chk("R9 second pin next", msg_valid == 1 && msg_pin == 5, msg_pin, 5);
        handshake;
        pin_in[1] = 0; pin_in[5] = 0; cfg_mask[1] = 1; cfg_mask[5] = 1; step(2);

        // R3 R5 R6 R8 level pin
        setpin(4, 8'h44, 8'h40, 0, 3'd1, 0, 1);
        pin_in[4] = 1; step(2);
        chk("R3 level message", msg_valid == 1 && msg_level == 1, msg_level, 1);
        handshake; step(3);
        chk("R5 remote flag blocks", msg_valid == 0, msg_valid, 0);
        svc_req[4] = 1; step(1); svc_req[4] = 0;
        chk("R3 merged while in service", coal == 8'h10, coal, 8'h10);
        eoi_vec = 8'h44; eoi_level = 0; eoi_valid = 1; step(1); eoi_valid = 0; step(3);
        chk("R6 edge-type EOI no effect", msg_valid == 0, msg_valid, 0);
        eoi_vec = 8'h55; eoi_level = 1; eoi_valid = 1; step(1); eoi_valid = 0; step(3);
        chk("R6 other vector no effect", msg_valid == 0, msg_valid, 0);
        eoi_vec = 8'h44; eoi_valid = 1; step(1); eoi_valid = 0; step(1);
        chk("R6 redelivery after EOI", msg_valid == 1 && msg_pin == 4, msg_pin, 4);
        handshake;
        pin_in[4] = 0; step(1);
        eoi_valid = 1; step(1); eoi_valid = 0; step(3);
        chk("R6 no redelivery when not pending", msg_valid == 0, msg_valid, 0);
        pin_in[4] = 1; step(2);
        chk("R3 fires after clear", msg_valid == 1, msg_valid, 1);
        handshake; step(2);
        rirr_clr[4] = 1; step(1); rirr_clr[4] = 0; step(1);
        chk("R5 clear input refires", msg_valid == 1 && msg_pin == 4, msg_valid, 1);
        handshake;
        cfg_vec[4*8 +: 8] = 8'h66; step(1);
        eoi_vec = 8'h66; eoi_valid = 1; step(1); eoi_valid = 0; step(3);
        chk("R8 stale map ignores EOI", msg_valid == 0, msg_valid, 0);
        cfg_changed = 1; step(1); cfg_changed = 0;
        eoi_valid = 1; step(1); eoi_valid = 0; step(1);
        chk("R8 rebuilt map accepts EOI", msg_valid == 1 && msg_vec == 8'h66, msg_vec, 8'h66);
        handshake; step(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule